// File: doc/BRIEF.md
# Banked ROM Cartridge Mapper

This block sits between a CPU with a 64 KB address space and a large ROM. It splits the CPU space into four 8 KB pages. Each page has its own 6-bit bank register, and the ROM address of a read is that bank number followed by the low 13 bits of the CPU address. The CPU space outside the four primary pages repeats them, so every CPU address lands in one of the four pages.

Bank numbers are written through small windows inside the pages. The page 2 bank register has a second job: when the all-ones bank value is written to it, a 2 KB window near the top of page 2 stops reading from ROM and selects an attached sound register block instead. Inside that window the sound block's 256-byte register set repeats. Any other value written to the same register closes the window again. The ROM contents and the sound generator are outside this block.

Top module: `rom_bank_mapper`

## Requirements
- R1: After a synchronous active-high reset, the bank register of page n holds the value n (n = 0..3) and the sound window is closed.
- R2: The page is chosen by CPU address bits 15:13: values 2, 3, 4, 5 (0x4000, 0x6000, 0x8000, 0xA000) select pages 0, 1, 2, 3. `rom_addr` equals {bank of that page, cpu_addr[12:0]}.
- R3: Bit-15:13 values 6, 7, 0, 1 (0xC000, 0xE000, 0x0000, 0x2000) repeat pages 0, 1, 2, 3, in the same way as R2.
- R4: A write anywhere in 0x5000-0x57FF, 0x7000-0x77FF, 0x9000-0x97FF or 0xB000-0xB7FF loads the bank register of page 0, 1, 2 or 3. A write anywhere else, including the repeated regions, leaves every bank register unchanged.
- R5: Only cpu_data[5:0] is stored in a bank register. Bits 7:6 are ignored.
- R6: A write to the page 2 bank window whose low six data bits equal 0x3F opens the sound window. A write there with any other low six bits closes it.
- R7: While the window is open, a read in 0x9800-0x9FFF raises `snd_sel` and not `rom_sel`. While it is closed, the same read raises `rom_sel`.
- R8: `rom_sel` is high only during a read outside an open sound window. `snd_sel` is high only during a read or a write inside an open sound window.
- R9: Writing 0x3F to the bank registers of pages 0, 1 or 3 does not open the sound window.
- R10: A bank write takes effect on `rom_addr` from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| rom_addr | output | 19 | Extended ROM address {bank, offset} |
| rom_sel | output | 1 | ROM chip select for reads |
| snd_sel | output | 1 | Sound register window select |

## Verification
The bench sweeps the whole 64 KB space in strides at each bank configuration, so a page swizzle that confuses a repeated region with its primary page shows up as a wrong bank in `rom_addr`. It writes just outside each bank window (0x4FFF, 0x5800, and the repeated 0xD000 and 0x1000). A decoder that is too wide would change a bank that should not move. It writes data with the top bits set and expects only the low six bits in the bank, which catches a wider register or a compare on the full byte. Setting the top bits on the page 2 value must still open the sound window. Writing 0x3F to the other pages must not open it, and a later different value on page 2 must close it again. A wrong unlock condition therefore moves reads at 0x9800-0x9FFF to the wrong chip select.

// File: rtl/rom_mapper_pkg.sv
package rom_mapper_pkg;

    localparam int CPU_AW     = 16;
    localparam int PAGE_AW    = 13;
    localparam int NUM_PAGES  = 4;
    localparam int PAGE_IDX_W = $clog2(NUM_PAGES);

    typedef logic [PAGE_IDX_W-1:0] page_idx_t;

    // Decoded view of one CPU address
    typedef struct packed {
        page_idx_t page;       // page the address maps to
        logic      bank_win;   // inside a bank-number write window
        logic      snd_win;    // inside the sound register window
    } addr_dec_t;

    // Bits 15:13 -> page: 2,3,4,5 and 6,7,0,1 both map to 0,1,2,3
    function automatic page_idx_t page_of(input logic [2:0] region);
        return {~region[1], region[0]};
    endfunction

    // Primary page regions are 2..5 (bit2 differs from bit1)
    function automatic logic is_primary(input logic [2:0] region);
        return region[2] ^ region[1];
    endfunction

endpackage

// File: rtl/mapper_decode.sv
module mapper_decode
    import rom_mapper_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    output addr_dec_t         dec
);
    logic [2:0] region;
    logic [1:0] sub;

    always_comb begin
        region       = addr[CPU_AW-1:PAGE_AW];
        sub          = addr[PAGE_AW-1:PAGE_AW-2];
        dec.page     = page_of(region);
        // bank window: upper-middle 2 KB quarter of each primary page
        dec.bank_win = is_primary(region) && (sub == 2'b10);
        // sound window: top 2 KB quarter of primary page 2 (0x8000 region)
        dec.snd_win  = (region == 3'b100) && (sub == 2'b11);
    end
endmodule

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs
    import rom_mapper_pkg::*;
#(
    parameter int          BANK_W      = 6,
    parameter int          UNLOCK_PAGE = 2,
    parameter logic [BANK_W-1:0] UNLOCK_CODE = '1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  page_idx_t                    wr_page,
    input  logic [BANK_W-1:0]            wr_bank,
    output logic [NUM_PAGES-1:0][BANK_W-1:0] banks,
    output logic                         snd_open
);
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        logic hit;
        assign hit = we && (wr_page == page_idx_t'(p));
        always_ff @(posedge clk) begin
            if (rst)      banks[p] <= BANK_W'(p);
            else if (hit) banks[p] <= wr_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            snd_open <= 1'b0;
        else if (we && wr_page == page_idx_t'(UNLOCK_PAGE))
            snd_open <= (wr_bank == UNLOCK_CODE);
    end
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
    import rom_mapper_pkg::*;
#(
    parameter int BANK_W  = 6,
    parameter int DATA_W  = 8,
    localparam int ROM_AW = BANK_W + PAGE_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel,
    output logic              snd_sel
);
    addr_dec_t                        dec;
    logic [NUM_PAGES-1:0][BANK_W-1:0] banks;
    logic                             snd_open;
    logic                             snd_hit;

    mapper_decode u_dec (
        .addr (cpu_addr),
        .dec  (dec)
    );

    mapper_bank_regs #(
        .BANK_W      (BANK_W),
        .UNLOCK_PAGE (2),
        .UNLOCK_CODE ('1)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cpu_wr && dec.bank_win),
        .wr_page  (dec.page),
        .wr_bank  (cpu_data[BANK_W-1:0]),
        .banks    (banks),
        .snd_open (snd_open)
    );

    always_comb begin
        snd_hit  = snd_open && dec.snd_win;
        rom_addr = {banks[dec.page], cpu_addr[PAGE_AW-1:0]};
        rom_sel  = cpu_rd && !snd_hit;
        snd_sel  = snd_hit && (cpu_rd || cpu_wr);
    end
endmodule

// File: rtl/rom_mapper_checker.sv
module rom_mapper_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic        cpu_wr,
    input logic        cpu_rd,
    input logic [18:0] rom_addr,
    input logic        rom_sel,
    input logic        snd_sel
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rom_sel && snd_sel)); // R7

    AST_ROMSEL_NEEDS_RD: assert property (@(posedge clk) disable iff (rst)
        rom_sel |-> cpu_rd); // R8

    AST_SNDSEL_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        snd_sel |-> ((cpu_rd || cpu_wr) && cpu_addr[15:11] == 5'h13)); // R8

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        rom_addr[12:0] == cpu_addr[12:0]); // R2

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(cpu_wr) && $stable(cpu_addr)) |-> $stable(rom_addr)); // R4

    AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(cpu_wr && cpu_addr[15:11] == 5'h12 && cpu_data[5:0] == 6'h3F)
         && cpu_rd && cpu_addr[15:11] == 5'h13) |-> snd_sel); // R6

    AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(cpu_wr && cpu_addr[15:11] == 5'h12 && cpu_data[5:0] != 6'h3F)
         && cpu_rd && cpu_addr[15:11] == 5'h13) |-> (rom_sel && !snd_sel)); // R6
endmodule

bind rom_bank_mapper rom_mapper_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .cpu_wr   (cpu_wr),
    .cpu_rd   (cpu_rd),
    .rom_addr (rom_addr),
    .rom_sel  (rom_sel),
    .snd_sel  (snd_sel)
);

// File: tb/tb_rom_bank_mapper.sv
module tb_rom_bank_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [18:0] rom_addr;
    logic        rom_sel;
    logic        snd_sel;

    int compared = 0;
    int mismatched = 0;
    logic [5:0] m_bank [4];
    logic       m_open;

    always #5 clk = ~clk;

    rom_bank_mapper dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_addr(rom_addr),
        .rom_sel(rom_sel), .snd_sel(snd_sel)
    );

    function automatic int exp_page(input logic [15:0] a);
        if (a >= 16'h4000 && a < 16'hC000) return (int'(a) - 32'h4000) / 32'h2000;
        if (a >= 16'hC000) return (int'(a) - 32'hC000) / 32'h2000;
        return (int'(a) / 32'h2000) + 2;
    endfunction

    function automatic logic in_snd_range(input logic [15:0] a);
        return a >= 16'h9800 && a <= 16'h9FFF;
    endfunction

    task automatic check_read(input logic [15:0] a, input string tag);
        logic [18:0] ea;
        logic es, er;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #2;
        es = m_open && in_snd_range(a);
        er = !es;
        ea = {m_bank[exp_page(a)], a[12:0]};
        compared++;
        if (rom_addr !== ea || rom_sel !== er || snd_sel !== es) begin
            mismatched++;
            $display("FAIL %s addr=%h actual rom_addr=%h rom_sel=%b snd_sel=%b expected %h %b %b",
                     tag, a, rom_addr, rom_sel, snd_sel, ea, er, es);
        end
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
        logic es;
        int pg;
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        #2;
        es = m_open && in_snd_range(a);
        compared++;
        if (rom_sel !== 1'b0 || snd_sel !== es) begin
            mismatched++;
            $display("FAIL %s R8 write addr=%h actual rom_sel=%b snd_sel=%b expected 0 %b",
                     tag, a, rom_sel, snd_sel, es);
        end
        @(negedge clk);
        cpu_wr = 1'b0;
        if ((a >= 16'h5000 && a <= 16'h57FF) || (a >= 16'h7000 && a <= 16'h77FF) ||
            (a >= 16'h9000 && a <= 16'h97FF) || (a >= 16'hB000 && a <= 16'hB7FF)) begin
            pg = (int'(a) - 32'h5000) / 32'h2000;
            m_bank[pg] = d[5:0];
            if (pg == 2) m_open = (d[5:0] == 6'h3F);
        end
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 65536; a += 97) check_read(16'(a), tag);
        check_read(16'h97FF, tag);
        check_read(16'h9800, tag);
        check_read(16'h9FFF, tag);
        check_read(16'hA000, tag);
        check_read(16'h1800, tag);
    endtask

    initial begin
        #1_500_000;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int p = 0; p < 4; p++) m_bank[p] = 6'(p);
        m_open = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state, R2 primary, R3 repeats
        check_read(16'h4000, "R1");
        check_read(16'h6123, "R1");
        check_read(16'h8000, "R1");
        check_read(16'hBFFF, "R1");
        check_read(16'h9800, "R1");
        sweep("R2_R3");
        // R4 R10 writes into each bank window, including window edges
        do_write(16'h5000, 8'h11, "R4");
        check_read(16'h4010, "R10");
        do_write(16'h77FF, 8'h22, "R4");
        do_write(16'h9400, 8'h33, "R4");
        do_write(16'hB7FF, 8'h2C, "R4");
        sweep("R2_R3");
        // R4 writes outside the windows must not move banks
        do_write(16'h4FFF, 8'h01, "R4");
        do_write(16'h5800, 8'h02, "R4");
        do_write(16'hD000, 8'h03, "R4");
        do_write(16'h1000, 8'h04, "R4");
        do_write(16'h3000, 8'h05, "R4");
        do_write(16'hF000, 8'h06, "R4");
        sweep("R4");
        // R5 upper data bits ignored
        do_write(16'h5123, 8'hC5, "R5");
        do_write(16'h7001, 8'h80, "R5");
        check_read(16'hC000, "R5");
        check_read(16'hE000, "R5");
        // R9 0x3F to other pages leaves window closed
        do_write(16'h5000, 8'h3F, "R9");
        do_write(16'h7000, 8'h3F, "R9");
        do_write(16'hB000, 8'h3F, "R9");
        check_read(16'h9800, "R9");
        check_read(16'h9C55, "R9");
        // R6 R7 open window with top bits set, then close
        do_write(16'h9000, 8'hFF, "R6");
        check_read(16'h9800, "R7");
        do_write(16'h9A00, 8'h12, "R8");
        check_read(16'h9F7F, "R7");
        check_read(16'h97FF, "R7");
        check_read(16'h1800, "R7");
        sweep("R7");
        do_write(16'h9000, 8'h3E, "R6");
        check_read(16'h9800, "R6");
        do_write(16'h97FF, 8'h3F, "R6");
        check_read(16'h9FFF, "R6");
        // R1 reset again restores banks and closes window
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int p = 0; p < 4; p++) m_bank[p] = 6'(p);
        m_open = 1'b0;
        check_read(16'h9800, "R1");
        sweep("R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule